// File: doc/BRIEF.md
# Power Management Event Register Block

This block keeps a 16-bit event status register and a 16-bit enable register for fixed power-management features. Both sit on a small register bus that does byte or word writes, with one byte-enable per lane, and reads without wait states. Three status bits are implemented. The real-time-clock alarm bit and the wake bit are sticky: hardware sets them, and software clears them by writing a 1 to the bit. The PCI Express wake bit is level-sensitive: it is set only when the system leaves sleep while one of its sources is active, and it cannot be cleared while any of those sources is still active.

The block also keeps a sleeping/working flag. A sleep-entry pulse sets the flag. While the block is sleeping, an enabled wake condition sets the wake bit, clears the flag and sends a one-cycle wake request to the power sequencer. An event output is asserted whenever an event-capable status bit and its matching enable bit are both 1. A separate pulse clears the enable register when the system comes up from a fully-off or soft-off condition.

Register map: address 0 selects status and address 1 selects enable. Byte lane 0 covers bits 7:0 and lane 1 covers bits 15:8. Status bit 10 is the alarm, bit 14 is the PCI Express wake bit and bit 15 is the wake bit. In the enable register, bit 10 enables the alarm event, bit 15 enables the wake event, and bit 14 disables PCI Express sources as a wake cause.

Top module: `pm_evt_regs`

## Requirements
- R1: After reset, both registers read 0, `sleeping`, `pmEvent` and `wakeReq` are 0.
- R2: A cycle with `rtcAlarm` high sets status bit 10 at the next edge. The bit stays set until a status write (address 0) with lane 1 enabled has data bit 10 = 1.
- R3: `pmEvent` is 1 exactly when (status[10] and enable[10]) or (status[15] and enable[15]), taken from the register values.
- R4: Status bits 13:11 and 9:0 always read 0. Writes to those positions change nothing.
- R5: Status bit 14 is set only on the edge where a wake fires (R8) while a PCI Express source (`pcieWakePin`, any bit of `pcieBeacon`, `pciePmeRcvd`) is active. An active source while working does not set it.
- R6: Status bit 14 is set regardless of enable bit 14. Enable bit 14 = 1 stops PCI Express sources from firing a wake.
- R7: A write of 1 to status bit 14 has no effect in a cycle where any PCI Express source is active.
- R8: While sleeping, `wakeEvent`, or an active PCI Express source with enable bit 14 = 0, fires a wake. At the next edge status bit 15 sets, `sleeping` clears and `wakeReq` is 1 for exactly that one cycle. A `sleepEnter` pulse while working sets `sleeping` at the next edge.
- R9: Status bit 14 = 1 on its own never fires a wake. The block stays sleeping.
- R10: An enable write (address 1) updates only the bytes whose lane enable is 1. A status write clears only bits in enabled lanes.
- R11: `offWake` clears the whole enable register at the next edge, even if an enable write happens in the same cycle.
- R12: When a hardware set and a write-1-to-clear reach a sticky bit in the same cycle, the bit ends up 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | Register write strobe |
| busAddr | input | 1 | 0 = status, 1 = enable |
| busBe | input | 2 | Byte-lane enables |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data of the selected register |
| rtcAlarm | input | 1 | Clock alarm indication |
| pcieWakePin | input | 1 | PCI Express wake pin active |
| pcieBeacon | input | NUM_PORTS | Per-port beacon detect |
| pciePmeRcvd | input | 1 | Power-management message received flag |
| wakeEvent | input | 1 | Generic enabled wake indication |
| sleepEnter | input | 1 | Enter sleeping state |
| offWake | input | 1 | Coming up from fully-off or soft-off |
| pmEvent | output | 1 | Power-management event |
| wakeReq | output | 1 | One-cycle request to move to working state |
| sleeping | output | 1 | Sleeping/working flag |

## Verification
The bench keeps a behavioural model and compares it with the design on every clock, alternating the read address so that both registers are checked. The alarm is tried as a single pulse, as a held level, and against a same-cycle clear; this shows a sticky set apart from a level follower. The PCI Express sources are tried one at a time, while working and while sleeping, with the disable bit at 0 and at 1, and with the sources held during a clear; this shows a transition-gated set apart from a plain level latch. Byte writes with only one lane enabled, and an enable write in the same cycle as an off-wake pulse, show up lane leakage and priority errors.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;
  localparam int REG_W    = 16;
  localparam int LANE_W   = 8;
  localparam int NUM_LANE = REG_W / LANE_W;
  localparam int RTC_BIT  = 10;
  localparam int PCIE_BIT = 14;
  localparam int WAK_BIT  = 15;
  localparam logic [REG_W-1:0] STS_IMPL = (REG_W'(1) << RTC_BIT) |
                                          (REG_W'(1) << PCIE_BIT) |
                                          (REG_W'(1) << WAK_BIT);
  localparam logic [REG_W-1:0] EVT_MASK = (REG_W'(1) << RTC_BIT) |
                                          (REG_W'(1) << WAK_BIT);

  typedef struct packed {
    logic [REG_W-1:0] stsClr;     // lane-gated write-1-to-clear mask
    logic [REG_W-1:0] enWrMask;   // lane-gated enable write mask
    logic             enClr;      // off-wake clear of enable
    logic             setRtc;
    logic             setPcie;
    logic             setWak;
    logic             pcieLevel;  // any PCIe source active
  } ctlStrobes_t;
endpackage

// File: rtl/pm_evt_ctrl.sv
module pm_evt_ctrl
  import pm_evt_pkg::*;
#(
  parameter int NUM_PORTS = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busWr,
  input  logic                 busAddr,
  input  logic [NUM_LANE-1:0]  busBe,
  input  logic [REG_W-1:0]     busWdata,
  input  logic                 rtcAlarm,
  input  logic                 pcieWakePin,
  input  logic [NUM_PORTS-1:0] pcieBeacon,
  input  logic                 pciePmeRcvd,
  input  logic                 wakeEvent,
  input  logic                 sleepEnter,
  input  logic                 offWake,
  input  logic                 pcieWakeDis,
  output ctlStrobes_t          strb,
  output logic                 sleeping,
  output logic                 wakeReq
);
  logic [REG_W-1:0] laneMask;
  logic             pcieSrc;
  logic             wakeFire;
  logic             sleepQ;
  logic             wakeReqQ;

  for (genvar l = 0; l < NUM_LANE; l++) begin : g_lane
    assign laneMask[l*LANE_W +: LANE_W] = {LANE_W{busBe[l]}};
  end

  always_comb begin
    pcieSrc  = pcieWakePin | (|pcieBeacon) | pciePmeRcvd;
    wakeFire = sleepQ & (wakeEvent | (pcieSrc & ~pcieWakeDis));
    strb.stsClr    = (busWr && !busAddr) ? (busWdata & laneMask) : '0;
    strb.enWrMask  = (busWr &&  busAddr) ? laneMask : '0;
    strb.enClr     = offWake;
    strb.setRtc    = rtcAlarm;
    strb.setPcie   = wakeFire & pcieSrc;
    strb.setWak    = wakeFire;
    strb.pcieLevel = pcieSrc;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sleepQ   <= 1'b0;
      wakeReqQ <= 1'b0;
    end else begin
      wakeReqQ <= wakeFire;
      if (wakeFire)        sleepQ <= 1'b0;
      else if (sleepEnter) sleepQ <= 1'b1;
    end
  end

  assign sleeping = sleepQ;
  assign wakeReq  = wakeReqQ;

  AST_WAKE_LEAVES_SLEEP: assert property (@(posedge clk) disable iff (!rstN)
    wakeReq |-> !sleeping); // R8
  AST_WAKE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    wakeReq && !$past(sleeping) |-> 1'b0 ); // R8
  AST_SLEEP_ENTER: assert property (@(posedge clk) disable iff (!rstN)
    sleepEnter && !strb.setWak |=> sleeping); // R8
  AST_NO_SELF_WAKE: assert property (@(posedge clk) disable iff (!rstN)
    sleeping && !wakeEvent && !pcieWakePin && !pciePmeRcvd && (pcieBeacon == '0)
    |=> sleeping); // R9
endmodule

// File: rtl/pm_evt_dp.sv
module pm_evt_dp
  import pm_evt_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobes_t      strb,
  input  logic             busAddr,
  input  logic [REG_W-1:0] busWdata,
  output logic [REG_W-1:0] busRdata,
  output logic             pmEvent,
  output logic             pcieWakeDis
);
  logic             rtcSts, pcieSts, wakSts;
  logic [REG_W-1:0] enReg;
  logic [REG_W-1:0] stsView;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rtcSts  <= 1'b0;
      pcieSts <= 1'b0;
      wakSts  <= 1'b0;
    end else begin
      rtcSts  <= strb.setRtc  | (rtcSts & ~strb.stsClr[RTC_BIT]);
      pcieSts <= strb.setPcie |
                 (pcieSts & ~(strb.stsClr[PCIE_BIT] & ~strb.pcieLevel));
      wakSts  <= strb.setWak  | (wakSts & ~strb.stsClr[WAK_BIT]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)           enReg <= '0;
    else if (strb.enClr) enReg <= '0;
    else                 enReg <= (enReg & ~strb.enWrMask) | (busWdata & strb.enWrMask);
  end

  always_comb begin
    stsView           = '0;
    stsView[RTC_BIT]  = rtcSts;
    stsView[PCIE_BIT] = pcieSts;
    stsView[WAK_BIT]  = wakSts;
    busRdata          = busAddr ? enReg : (stsView & STS_IMPL);
    pmEvent           = |(stsView & enReg & EVT_MASK);
    pcieWakeDis       = enReg[PCIE_BIT];
  end

  AST_RTC_SET: assert property (@(posedge clk) disable iff (!rstN)
    strb.setRtc |=> rtcSts); // R2
  AST_SET_BEATS_CLR: assert property (@(posedge clk) disable iff (!rstN)
    strb.setWak && strb.stsClr[WAK_BIT] |=> wakSts); // R12
  AST_PCIE_ONLY_AT_WAKE: assert property (@(posedge clk) disable iff (!rstN)
    !pcieSts && !strb.setPcie |=> !pcieSts); // R5
  AST_PCIE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    pcieSts && strb.pcieLevel |=> pcieSts); // R7
  AST_EN_OFFCLR: assert property (@(posedge clk) disable iff (!rstN)
    strb.enClr |=> (enReg == '0)); // R11
endmodule

// File: rtl/pm_evt_regs.sv
module pm_evt_regs
  import pm_evt_pkg::*;
#(
  parameter int NUM_PORTS = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busWr,
  input  logic                 busAddr,
  input  logic [1:0]           busBe,
  input  logic [15:0]          busWdata,
  output logic [15:0]          busRdata,
  input  logic                 rtcAlarm,
  input  logic                 pcieWakePin,
  input  logic [NUM_PORTS-1:0] pcieBeacon,
  input  logic                 pciePmeRcvd,
  input  logic                 wakeEvent,
  input  logic                 sleepEnter,
  input  logic                 offWake,
  output logic                 pmEvent,
  output logic                 wakeReq,
  output logic                 sleeping
);
  ctlStrobes_t strb;
  logic        pcieWakeDis;

  pm_evt_ctrl #(.NUM_PORTS(NUM_PORTS)) uCtrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr), .busBe(busBe),
    .busWdata(busWdata), .rtcAlarm(rtcAlarm), .pcieWakePin(pcieWakePin),
    .pcieBeacon(pcieBeacon), .pciePmeRcvd(pciePmeRcvd), .wakeEvent(wakeEvent),
    .sleepEnter(sleepEnter), .offWake(offWake), .pcieWakeDis(pcieWakeDis),
    .strb(strb), .sleeping(sleeping), .wakeReq(wakeReq)
  );

  pm_evt_dp uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .pmEvent(pmEvent), .pcieWakeDis(pcieWakeDis)
  );

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !busAddr |-> (busRdata[13:11] == 3'b000) && (busRdata[9:0] == 10'd0)); // R4
endmodule

// File: tb/pm_evt_regs_test.sv
module pm_evt_regs_test;
  localparam int NP = 4;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWr = 1'b0, busAddr = 1'b0;
  logic [1:0] busBe = 2'b00;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic rtcAlarm = 0, pcieWakePin = 0, pciePmeRcvd = 0, wakeEvent = 0;
  logic sleepEnter = 0, offWake = 0;
  logic [NP-1:0] pcieBeacon = '0;
  logic pmEvent, wakeReq, sleeping;

  int checks = 0, fails = 0, cycles = 0;
  bit checking = 0;
  string curReq = "R1";

  int mSts = 0, mEn = 0, mSleep = 0, mWakeReq = 0;

  always #4 clk = ~clk;

  pm_evt_regs #(.NUM_PORTS(NP)) uut (.*);

  // reference model
  always @(posedge clk) begin
    if (!rstN) begin
      mSts = 0; mEn = 0; mSleep = 0; mWakeReq = 0;
    end else begin
      int lane, clr, nSts, nEn, nSleep;
      bit src, trig;
      src  = pcieWakePin || (pcieBeacon != 0) || pciePmeRcvd;
      trig = (mSleep != 0) && (wakeEvent || (src && ((mEn >> 14) & 1) == 0));
      lane = (busBe[1] ? 'hFF00 : 0) | (busBe[0] ? 'h00FF : 0);
      clr  = (busWr && !busAddr) ? (busWdata & lane) : 0;
      nSts = 0;
      if (rtcAlarm || ((mSts & 'h0400) && !(clr & 'h0400))) nSts |= 'h0400;
      if ((trig && src) || ((mSts & 'h4000) && !((clr & 'h4000) && !src))) nSts |= 'h4000;
      if (trig || ((mSts & 'h8000) && !(clr & 'h8000))) nSts |= 'h8000;
      if (offWake) nEn = 0;
      else if (busWr && busAddr) nEn = (mEn & ~lane) | (busWdata & lane);
      else nEn = mEn;
      nSleep = trig ? 0 : (sleepEnter ? 1 : mSleep);
      mSts = nSts; mEn = nEn & 'hFFFF; mSleep = nSleep; mWakeReq = trig;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (checking) begin
      int expRd, expEv;
      expRd = busAddr ? mEn : (mSts & 'hC400);
      expEv = (((mSts & mEn) & 'h8400) != 0);
      chk(curReq, "busRdata", busRdata, expRd);
      chk(curReq, "pmEvent", pmEvent, expEv);
      chk(curReq, "wakeReq", wakeReq, mWakeReq);
      chk(curReq, "sleeping", sleeping, mSleep);
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      step(); busWr = 0; busAddr = ~busAddr;
    end
  endtask

  task automatic wr(bit a, logic [1:0] be, logic [15:0] d);
    step(); busWr = 1; busAddr = a; busBe = be; busWdata = d;
    step(); busWr = 0; busBe = 0;
  endtask

  task automatic pulse(ref logic s);
    step(); s = 1; step(); s = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 checking = 1;
    curReq = "R1"; idle(2);
    step(); rstN = 1; idle(2);
    // R2 alarm pulse, sticky, clear needs lane 1
    curReq = "R2"; pulse(rtcAlarm); idle(3);
    curReq = "R10"; wr(0, 2'b01, 16'hFFFF); idle(2);
    curReq = "R2"; wr(0, 2'b10, 16'h0400); idle(2);
    // R3 event
    curReq = "R3"; wr(1, 2'b11, 16'h0400); pulse(rtcAlarm); idle(2);
    wr(0, 2'b11, 16'h0400); idle(2);
    // R4 reserved
    curReq = "R4"; wr(0, 2'b11, 16'h3BFF); idle(2);
    // R12 held alarm vs clear
    curReq = "R12"; step(); rtcAlarm = 1; busWr = 1; busAddr = 0; busBe = 2'b11; busWdata = 16'h0400;
    step(); busWr = 0; rtcAlarm = 0; idle(2);
    wr(0, 2'b11, 16'h0400);
    // R8 sleep and generic wake
    curReq = "R8"; wr(1, 2'b11, 16'h8000); pulse(sleepEnter); idle(3);
    pulse(wakeEvent); idle(3);
    curReq = "R12"; step(); sleepEnter = 1; step(); sleepEnter = 0;
    wakeEvent = 1; busWr = 1; busAddr = 0; busBe = 2'b10; busWdata = 16'h8000;
    step(); wakeEvent = 0; busWr = 0; idle(2);
    wr(0, 2'b11, 16'h8000);
    // R5 source while working, then beacon wakes
    curReq = "R5"; step(); pcieWakePin = 1; idle(3); pcieWakePin = 0;
    pulse(sleepEnter); idle(2);
    step(); pcieBeacon = 4'b0010; idle(3);
    // R7 clear while held, then released
    curReq = "R7"; wr(0, 2'b11, 16'hC000); idle(2);
    step(); pcieBeacon = 0; wr(0, 2'b11, 16'h4000); idle(2);
    // R6 disable set: pme does not wake, bit still set on wake
    curReq = "R6"; wr(1, 2'b11, 16'h4000); pulse(sleepEnter);
    step(); pciePmeRcvd = 1; idle(4);
    pulse(wakeEvent); idle(2); pciePmeRcvd = 0; idle(1);
    // R9 bit 14 alone does not wake
    curReq = "R9"; pulse(sleepEnter); idle(6);
    pulse(wakeEvent); idle(2);
    wr(0, 2'b11, 16'hC000);
    // R10 enable word/byte writes
    curReq = "R10"; wr(1, 2'b11, 16'hA55A); idle(2);
    wr(1, 2'b01, 16'hFF00); idle(1); wr(1, 2'b10, 16'h12FF); idle(2);
    // R11 off-wake beats write
    curReq = "R11"; step(); busWr = 1; busAddr = 1; busBe = 2'b11; busWdata = 16'hFFFF; offWake = 1;
    step(); busWr = 0; offWake = 0; idle(2);
    wr(1, 2'b11, 16'h0F0F); pulse(offWake); idle(2);
    curReq = "R1"; step(); rstN = 0; idle(2); rstN = 1; idle(2);
    checking = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<20000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule